// File: doc/BRIEF.md
# Core-Miss Migrate-or-Remote Decision Unit

This block sits beside each core of a 2D-mesh multicore in which every physical address has exactly one home core that may cache it. For every memory access it receives the physical address, the ID of the core issuing it, the ID of the running thread's native core, and a hop-distance threshold. It extracts the home core from a fixed bit field of the address. It then computes the Manhattan hop distance from the current core to that home core. Finally it picks one of three actions: serve locally, send a round-trip remote request to the home core, or move the thread's execution context to the home core.

The choice is made combinationally and captured in one output register. Accesses enter over a valid/ready handshake and results leave over another. A result that the consumer has not yet taken stays frozen on the output. While it waits, the input side de-asserts ready, so back-pressure passes straight upstream. On a cycle where the consumer takes the held result, a new access can be accepted in the same cycle. The threshold is a plain control pin that is sampled together with each accepted access.

Core IDs are packed as `{y, x}`, with the X coordinate in the low `X_BITS` bits. The core count is `2**(X_BITS+Y_BITS)`, which is a power of two.

Top module: `mig_decide_top`

## Requirements
- R1: The home core is `in_addr[HOME_LSB +: CORE_W]`, where `CORE_W = X_BITS+Y_BITS`, and it is reported on `out_home`.
- R2: If the home core equals the current core, the action code is 0 (local). This holds whatever the native core and the threshold are.
- R3: If the home core differs from the current core and equals the native core, the action code is 2 (migrate), whatever the distance and threshold.
- R4: In every other case, the action code is 2 (migrate) when the hop count is strictly greater than `dist_thresh`.
- R5: In every other case, the action code is 1 (remote) when the hop count is less than or equal to `dist_thresh`; a hop count equal to the threshold gives remote.
- R6: `out_hops` is |x_cur - x_home| + |y_cur - y_home|. Here x is the low `X_BITS` bits of a core ID and y is the next `Y_BITS` bits.
- R7: An access is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its result is on the outputs with `out_valid` = 1 immediately after that edge.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_action`, `out_home` and `out_hops` do not change.
- R9: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Access present |
| in_ready | output | 1 | Access can be taken this cycle |
| in_addr | input | ADDR_W | Physical address |
| in_cur_core | input | CORE_W | ID of the core issuing the access |
| in_native_core | input | CORE_W | Native core ID of the running thread |
| dist_thresh | input | HOP_W | Hop threshold, sampled with the access |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_action | output | 2 | 0 local, 1 remote, 2 migrate |
| out_home | output | CORE_W | Home core of the address |
| out_hops | output | HOP_W | Hop distance current-to-home |

## Verification
All results are due one edge after acceptance. The bench drives inputs on the falling edge and checks the outputs at the following falling edge, which is after the single capturing edge. In the back-pressure sequence, the held result is sampled again at each falling edge while `out_ready` is low. The accept of the next access happens on the same edge where the held result drains, and its result is checked at the falling edge after that edge. `in_ready` is a combinational output, so it is checked within the same half cycle in which `out_ready` changes.

// File: rtl/mig_decide_pkg.sv
package mig_decide_pkg;
  typedef enum logic [1:0] {
    ACT_LOCAL   = 2'd0,
    ACT_REMOTE  = 2'd1,
    ACT_MIGRATE = 2'd2
  } act_e;
endpackage

// File: rtl/home_core_map.sv
module home_core_map #(
  parameter int ADDR_W   = 32,
  parameter int HOME_LSB = 12,
  parameter int CORE_W   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CORE_W-1:0] home
);
  localparam logic [ADDR_W-1:0] FIELD_MASK =
    ADDR_W'(((64'd1 << CORE_W) - 64'd1) << HOME_LSB);

  logic unused_addr;
  assign unused_addr = ^(addr & ~FIELD_MASK);
  assign home = addr[HOME_LSB +: CORE_W];
endmodule

// File: rtl/mesh_hop_dist.sv
module mesh_hop_dist #(
  parameter int X_BITS = 2,
  parameter int Y_BITS = 2
) (
  input  logic [X_BITS+Y_BITS-1:0] core_a,
  input  logic [X_BITS+Y_BITS-1:0] core_b,
  output logic [((X_BITS > Y_BITS) ? X_BITS : Y_BITS):0] hops
);
  localparam int HOP_W = ((X_BITS > Y_BITS) ? X_BITS : Y_BITS) + 1;

  logic [X_BITS-1:0] xa, xb, dx;
  logic [Y_BITS-1:0] ya, yb, dy;

  assign xa = core_a[X_BITS-1:0];
  assign xb = core_b[X_BITS-1:0];
  assign ya = core_a[X_BITS +: Y_BITS];
  assign yb = core_b[X_BITS +: Y_BITS];

  always_comb begin
    dx = (xa > xb) ? (xa - xb) : (xb - xa);
    dy = (ya > yb) ? (ya - yb) : (yb - ya);
  end

  assign hops = HOP_W'(dx) + HOP_W'(dy);
endmodule

// File: rtl/action_select.sv
module action_select
  import mig_decide_pkg::*;
#(
  parameter int CORE_W = 4,
  parameter int HOP_W  = 3
) (
  input  logic [CORE_W-1:0] home,
  input  logic [CORE_W-1:0] cur,
  input  logic [CORE_W-1:0] native,
  input  logic [HOP_W-1:0]  hops,
  input  logic [HOP_W-1:0]  thresh,
  output act_e              action
);
  always_comb begin
    if (home == cur)          action = ACT_LOCAL;
    else if (home == native)  action = ACT_MIGRATE;
    else if (hops > thresh)   action = ACT_MIGRATE;
    else                      action = ACT_REMOTE;
  end
endmodule

// File: rtl/result_reg.sv
module result_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mig_decide_top.sv
module mig_decide_top
  import mig_decide_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int HOME_LSB = 12,
  parameter int X_BITS   = 2,
  parameter int Y_BITS   = 2,
  localparam int CORE_W  = X_BITS + Y_BITS,
  localparam int HOP_W   = ((X_BITS > Y_BITS) ? X_BITS : Y_BITS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CORE_W-1:0] in_cur_core,
  input  logic [CORE_W-1:0] in_native_core,
  input  logic [HOP_W-1:0]  dist_thresh,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_action,
  output logic [CORE_W-1:0] out_home,
  output logic [HOP_W-1:0]  out_hops
);
  localparam int PACK_W = 2 + CORE_W + HOP_W;

  logic [CORE_W-1:0] home_c;
  logic [HOP_W-1:0]  hops_c;
  act_e              act_c;
  logic [PACK_W-1:0] pack_in, pack_out;

  home_core_map #(.ADDR_W(ADDR_W), .HOME_LSB(HOME_LSB), .CORE_W(CORE_W)) map_i (
    .addr (in_addr),
    .home (home_c)
  );

  mesh_hop_dist #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) dist_i (
    .core_a (in_cur_core),
    .core_b (home_c),
    .hops   (hops_c)
  );

  action_select #(.CORE_W(CORE_W), .HOP_W(HOP_W)) sel_i (
    .home   (home_c),
    .cur    (in_cur_core),
    .native (in_native_core),
    .hops   (hops_c),
    .thresh (dist_thresh),
    .action (act_c)
  );

  assign pack_in = {act_c, home_c, hops_c};

  result_reg #(.W(PACK_W)) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pack_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pack_out)
  );

  assign out_action = pack_out[PACK_W-1 -: 2];
  assign out_home   = pack_out[HOP_W +: CORE_W];
  assign out_hops   = pack_out[HOP_W-1:0];
endmodule

// File: rtl/mig_decide_chk.sv
module mig_decide_chk #(
  parameter int ADDR_W   = 32,
  parameter int HOME_LSB = 12,
  parameter int X_BITS   = 2,
  parameter int Y_BITS   = 2,
  localparam int CORE_W  = X_BITS + Y_BITS,
  localparam int HOP_W   = ((X_BITS > Y_BITS) ? X_BITS : Y_BITS) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic [CORE_W-1:0] in_cur_core,
  input logic [CORE_W-1:0] in_native_core,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_action,
  input logic [CORE_W-1:0] out_home,
  input logic [HOP_W-1:0]  out_hops
);
  logic [CORE_W-1:0] fld;
  assign fld = in_addr[HOME_LSB +: CORE_W];

  assert_accept_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_action)
                                   && $stable(out_home) && $stable(out_hops)));

  assert_local_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && fld == in_cur_core) |=> (out_action == 2'd0 && out_hops == '0));

  assert_native_migrates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && fld != in_cur_core && fld == in_native_core)
      |=> out_action == 2'd2);

  assert_home_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_home == $past(fld));

  assert_remote_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_action == 2'd1) |-> out_hops != '0);

  assert_code_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_action != 2'd3);
endmodule

bind mig_decide_top mig_decide_chk #(
  .ADDR_W(ADDR_W), .HOME_LSB(HOME_LSB), .X_BITS(X_BITS), .Y_BITS(Y_BITS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_addr(in_addr), .in_cur_core(in_cur_core), .in_native_core(in_native_core),
  .out_valid(out_valid), .out_ready(out_ready), .out_action(out_action),
  .out_home(out_home), .out_hops(out_hops)
);

// File: tb/mig_decide_top_tb_top.sv
module mig_decide_top_tb_top;
  localparam int ADDR_W = 32, HOME_LSB = 12, XB = 2, YB = 2;
  localparam int CW = XB + YB, HW = 3;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1;
  logic in_ready, out_valid;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [CW-1:0] in_cur = '0, in_nat = '0;
  logic [HW-1:0] thr = '0;
  logic [1:0] out_action;
  logic [CW-1:0] out_home;
  logic [HW-1:0] out_hops;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  mig_decide_top #(.ADDR_W(ADDR_W), .HOME_LSB(HOME_LSB), .X_BITS(XB), .Y_BITS(YB)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_cur_core(in_cur), .in_native_core(in_nat),
    .dist_thresh(thr), .out_valid(out_valid), .out_ready(out_ready),
    .out_action(out_action), .out_home(out_home), .out_hops(out_hops));

  function automatic int ref_hops(input int a, input int b);
    int ax = a % 4, ay = a / 4, bx = b % 4, by = b / 4;
    int dx = ax > bx ? ax - bx : bx - ax;
    int dy = ay > by ? ay - by : by - ay;
    return dx + dy;
  endfunction

  function automatic int ref_act(input int home, input int cur, input int nat, input int t);
    if (home == cur) return 0;
    if (home == nat) return 2;
    if (ref_hops(cur, home) > t) return 2;
    return 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [ADDR_W-1:0] a, input int cur, input int nat,
                      input int t, input string req);
    int home = int'(a[HOME_LSB +: CW]);
    @(negedge clk);
    in_addr = a; in_cur = CW'(cur); in_nat = CW'(nat); thr = HW'(t);
    in_valid = 1; out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk({req, " R7 valid"}, int'(out_valid), 1);
    chk({req, " action"}, int'(out_action), ref_act(home, cur, nat, t));
    chk({req, " R1 home"}, int'(out_home), home);
    chk({req, " R6 hops"}, int'(out_hops), ref_hops(cur, home));
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int home, input int noise);
    logic [ADDR_W-1:0] v = ADDR_W'(noise);
    v[HOME_LSB +: CW] = CW'(home);
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] ha; logic [CW-1:0] hh; logic [HW-1:0] hp;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R10 out_valid", int'(out_valid), 0);
    chk("R10 in_ready", int'(in_ready), 1);
    rst_n = 1;
    @(negedge clk);
    chk("R10 out_valid after release", int'(out_valid), 0);

    send(mk(5, 32'h0ABC), 5, 9, 0, "R2 local even at thr0");
    send(mk(5, 32'h0123), 5, 5, 7, "R2 local when native too");
    send(mk(15, 32'h0001), 0, 15, 7, "R3 native far thr max");
    send(mk(1, 32'h0002), 0, 1, 7, "R3 native adjacent");
    send(mk(6, 32'h0000), 0, 3, 3, "R5 equal thr remote");
    send(mk(6, 32'h0000), 0, 3, 2, "R4 just above thr");
    send(mk(4, 32'h0FFF), 0, 9, 0, "R4 adjacent thr0");
    send(mk(15, 32'h0000), 0, 2, 6, "R5 corner eq thr");
    send(mk(15, 32'h0000), 0, 2, 5, "R4 corner over thr");
    send(mk(12, 32'hFFFF_0FFF), 3, 8, 7, "R5 max thr remote");

    // R8/R9 back-pressure
    @(negedge clk);
    in_addr = mk(10, 0); in_cur = 0; in_nat = 1; thr = 1; in_valid = 1; out_ready = 0;
    @(negedge clk);
    chk("R7 held valid", int'(out_valid), 1);
    chk("R9 ready low", int'(in_ready), 0);
    ha = out_action; hh = out_home; hp = out_hops;
    chk("R4 held action", int'(ha), 2);
    in_addr = mk(1, 0); in_cur = 0; in_nat = 7; thr = 1;
    @(negedge clk);
    chk("R8 valid held", int'(out_valid), 1);
    chk("R8 action held", int'(out_action), int'(ha));
    chk("R8 home held", int'(out_home), int'(hh));
    chk("R8 hops held", int'(out_hops), int'(hp));
    out_ready = 1;
    #1;
    chk("R9 ready with drain", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 0;
    chk("R7 next result", int'(out_valid), 1);
    chk("R5 next action", int'(out_action), 1);
    chk("R1 next home", int'(out_home), 1);
    @(negedge clk);
    chk("R9 drained valid", int'(out_valid), 0);
    chk("R9 ready idle", int'(in_ready), 1);

    for (int i = 0; i < 400; i++) begin
      int c = int'($urandom_range(0, 15));
      int n = int'($urandom_range(0, 15));
      int t = int'($urandom_range(0, 7));
      send($urandom(), c, n, t, "R6 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule